// File: doc/BRIEF.md
# Atomic Fetch-and-Operate Unit

The unit carries out one indivisible read-modify-write on a small internal memory of doubleword lines. A requester gives a byte address, a 64-bit operand, a 5-bit function code and a size select (4-byte word or 8-byte doubleword). For the implemented codes the unit reads the addressed location and combines it with the operand. It writes the combined value back and returns the value that was there before, zero-extended to 64 bits when the size is a word. Requests that cannot be performed are refused with a one-cycle fault pulse and a cause code. The memory is never written for a refused request.

A state machine sequences every request: `ST_IDLE` accepts a request. On a clean decode, `ST_IDLE -> ST_READ` starts the memory read. `ST_READ -> ST_CALC` applies the combine. `ST_CALC -> ST_WRITE` writes the new value back. `ST_WRITE -> ST_RESP` presents the old value, and `ST_RESP -> ST_IDLE` ends the request. On a faulting decode the path is `ST_IDLE -> ST_FAULT -> ST_IDLE`. The `busy` output is high in every state except `ST_IDLE`, and requests that arrive while it is high are dropped. Nothing can therefore reach the memory between the read and the write-back.

Top module: `amo_fetch_unit`

## Requirements
- R1: After reset `busy`, `rsp_valid` and `fault_valid` are low, `fault_cause` is 0, and every memory location reads as zero.
- R2: Function code 0 adds the operand to the location, wrapping modulo the operand width with no carry out, and returns the old value.
- R3: Function codes 1, 2 and 3 write back old XOR operand, old OR operand and old AND operand respectively, and return the old value.
- R4: Function code 8 writes the operand to the location and returns the old value.
- R5: With `req_dword`=0 only operand bits 31:0 are used. Address bit 2 picks bits 63:32 (1) or bits 31:0 (0) of the doubleword line at address bits N:3, and the other half of that line is left unchanged. The returned value has bits 63:32 zero.
- R6: A word request with address bits 1:0 not zero, or a doubleword request with address bits 2:0 not zero, faults with cause 1 (alignment). This cause applies whatever the function code is.
- R7: Function codes 4, 5, 6, 7, 16, 24, 25 and 28 on an aligned address fault with cause 2 (illegal instruction).
- R8: Every other function code (9 to 15, 17 to 23, 26, 27, 29 to 31) on an aligned address faults with cause 3 (data storage).
- R9: A faulting request writes nothing to memory and never raises `rsp_valid`. `fault_valid` is high for exactly one cycle, and `fault_cause` is 0 whenever `fault_valid` is low.
- R10: `busy` is high from the accepting edge until the request finishes. A request presented while `busy` is high is ignored and alters no memory location.
- R11: `fault_valid` is high in the first cycle after the accepting clock edge, and `rsp_valid` in the fourth. Each is high for exactly one cycle, after which `busy` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present; taken when `busy` is low |
| req_addr | input | ADDR_W | Byte address (ADDR_W = log2(DEPTH)+3) |
| req_fc | input | 5 | Function code |
| req_dword | input | 1 | 1 = doubleword, 0 = word |
| req_operand | input | 64 | Operand value |
| busy | output | 1 | A request is in progress |
| rsp_valid | output | 1 | One-cycle pulse carrying the old value |
| rsp_data | output | 64 | Old value, zero-extended for words |
| fault_valid | output | 1 | One-cycle fault pulse |
| fault_cause | output | 2 | 1 alignment, 2 illegal, 3 data storage |

## Verification
Two checks meet in the same decode cycle: the alignment check and the function-code classification. The sweep sends every one of the 32 codes with aligned addresses and with misaligned ones. Doubleword requests at a word-aligned offset of 4 are included, so both faults can be true at once. The bench judges that only cause 1 appears in those cases and that the memory image is unchanged afterwards. A second overlap, a new request arriving while a read-modify-write is in flight, is provoked by holding `req_valid` through the busy window. It is judged by a single response and an untouched target line.

// File: rtl/amo_pkg.sv
package amo_pkg;

    localparam int DATA_W = 64;
    localparam int HALF_W = DATA_W / 2;
    localparam int FC_W   = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_CALC,
        ST_WRITE,
        ST_RESP,
        ST_FAULT
    } amo_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'd0,
        CAUSE_ALIGN   = 2'd1,
        CAUSE_ILLEGAL = 2'd2,
        CAUSE_STORAGE = 2'd3
    } amo_cause_e;

    typedef enum logic [2:0] {
        OP_ADD,
        OP_XOR,
        OP_OR,
        OP_AND,
        OP_SWAP
    } amo_op_e;

endpackage

// File: rtl/amo_decode.sv
module amo_decode
    import amo_pkg::*;
(
    input  logic [FC_W-1:0] fc,
    input  logic            dword,
    input  logic [2:0]      addr_lo,
    output amo_op_e         op,
    output amo_cause_e      cause
);

    logic       misaligned;
    amo_cause_e code_class;

    always_comb begin
        misaligned = dword ? (addr_lo != 3'd0) : (addr_lo[1:0] != 2'd0);
    end

    always_comb begin
        op         = OP_ADD;
        code_class = CAUSE_NONE;
        unique case (fc)
            5'd0:  op = OP_ADD;
            5'd1:  op = OP_XOR;
            5'd2:  op = OP_OR;
            5'd3:  op = OP_AND;
            5'd8:  op = OP_SWAP;
            5'd4, 5'd5, 5'd6, 5'd7,
            5'd16, 5'd24, 5'd25, 5'd28:
                   code_class = CAUSE_ILLEGAL;
            default:
                   code_class = CAUSE_STORAGE;
        endcase
    end

    // Alignment is judged before the function code.
    always_comb begin
        if (misaligned) begin
            cause = CAUSE_ALIGN;
        end else begin
            cause = code_class;
        end
    end

endmodule

// File: rtl/amo_combine.sv
module amo_combine
    import amo_pkg::*;
#(
    parameter int W = 64
) (
    input  amo_op_e      op,
    input  logic [W-1:0] mem_val,
    input  logic [W-1:0] operand,
    output logic [W-1:0] result
);

    always_comb begin
        unique case (op)
            OP_ADD:  result = mem_val + operand;
            OP_XOR:  result = mem_val ^ operand;
            OP_OR:   result = mem_val | operand;
            OP_AND:  result = mem_val & operand;
            OP_SWAP: result = operand;
            default: result = mem_val;
        endcase
    end

endmodule

// File: rtl/amo_alu.sv
module amo_alu
    import amo_pkg::*;
(
    input  amo_op_e           op,
    input  logic              dword,
    input  logic              hi_sel,
    input  logic [DATA_W-1:0] old_line,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] new_line,
    output logic [DATA_W-1:0] old_ext
);

    localparam int N_WIDTHS = 2;

    logic [HALF_W-1:0] old_half;
    logic [HALF_W-1:0] new_half;
    logic [DATA_W-1:0] new_full;

    always_comb begin
        old_half = hi_sel ? old_line[DATA_W-1:HALF_W] : old_line[HALF_W-1:0];
    end

    // One combiner per supported operand width.
    for (genvar g = 0; g < N_WIDTHS; g++) begin : g_width
        if (g == 0) begin : g_half
            amo_combine #(.W(HALF_W)) comb_i (
                .op      (op),
                .mem_val (old_half),
                .operand (operand[HALF_W-1:0]),
                .result  (new_half)
            );
        end else begin : g_full
            amo_combine #(.W(DATA_W)) comb_i (
                .op      (op),
                .mem_val (old_line),
                .operand (operand),
                .result  (new_full)
            );
        end
    end

    always_comb begin
        if (dword) begin
            new_line = new_full;
            old_ext  = old_line;
        end else begin
            old_ext = {{HALF_W{1'b0}}, old_half};
            if (hi_sel) begin
                new_line = {new_half, old_line[HALF_W-1:0]};
            end else begin
                new_line = {old_line[DATA_W-1:HALF_W], new_half};
            end
        end
    end

endmodule

// File: rtl/amo_mem.sv
module amo_mem
    import amo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data
);

    logic [DATA_W-1:0] lines [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                lines[i] <= '0;
            end
        end else if (wr_en) begin
            lines[wr_idx] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= lines[rd_idx];
        end
    end

    // A read and a write never overlap: the sequencer separates them.
    p_no_rw_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en));

endmodule

// File: rtl/amo_fetch_unit.sv
module amo_fetch_unit
    import amo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int ADDR_W = IDX_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [FC_W-1:0]   req_fc,
    input  logic              req_dword,
    input  logic [DATA_W-1:0] req_operand,
    output logic              busy,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              fault_valid,
    output logic [1:0]        fault_cause
);

    amo_state_e state_q, state_d;

    amo_op_e    dec_op;
    amo_cause_e dec_cause;

    logic              accept;
    logic [IDX_W-1:0]  lat_idx;
    logic              lat_hi;
    logic              lat_dword;
    amo_op_e           lat_op;
    amo_cause_e        lat_cause;
    logic [DATA_W-1:0] lat_operand;
    logic [DATA_W-1:0] old_q;
    logic [DATA_W-1:0] new_q;

    logic              mem_rd_en;
    logic              mem_we;
    logic [DATA_W-1:0] mem_rd_data;
    logic [DATA_W-1:0] alu_new;
    logic [DATA_W-1:0] alu_old;

    amo_decode dec_i (
        .fc      (req_fc),
        .dword   (req_dword),
        .addr_lo (req_addr[2:0]),
        .op      (dec_op),
        .cause   (dec_cause)
    );

    amo_mem #(.DEPTH(DEPTH)) mem_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (mem_rd_en),
        .rd_idx  (lat_idx),
        .rd_data (mem_rd_data),
        .wr_en   (mem_we),
        .wr_idx  (lat_idx),
        .wr_data (new_q)
    );

    amo_alu alu_i (
        .op       (lat_op),
        .dword    (lat_dword),
        .hi_sel   (lat_hi),
        .old_line (mem_rd_data),
        .operand  (lat_operand),
        .new_line (alu_new),
        .old_ext  (alu_old)
    );

    assign accept = req_valid && (state_q == ST_IDLE);

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = (dec_cause == CAUSE_NONE) ? ST_READ : ST_FAULT;
                end
            end
            ST_READ:  state_d = ST_CALC;
            ST_CALC:  state_d = ST_WRITE;
            ST_WRITE: state_d = ST_RESP;
            ST_RESP:  state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Request capture and read-modify-write datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_idx     <= '0;
            lat_hi      <= 1'b0;
            lat_dword   <= 1'b0;
            lat_op      <= OP_ADD;
            lat_cause   <= CAUSE_NONE;
            lat_operand <= '0;
            old_q       <= '0;
            new_q       <= '0;
        end else begin
            if (accept) begin
                lat_idx     <= req_addr[ADDR_W-1:3];
                lat_hi      <= req_addr[2];
                lat_dword   <= req_dword;
                lat_op      <= dec_op;
                lat_cause   <= dec_cause;
                lat_operand <= req_operand;
            end
            if (state_q == ST_CALC) begin
                old_q <= alu_old;
                new_q <= alu_new;
            end
        end
    end

    // Outputs decoded from the state
    always_comb begin
        busy        = 1'b1;
        mem_rd_en   = 1'b0;
        mem_we      = 1'b0;
        rsp_valid   = 1'b0;
        rsp_data    = '0;
        fault_valid = 1'b0;
        fault_cause = CAUSE_NONE;
        unique case (state_q)
            ST_IDLE:  busy = 1'b0;
            ST_READ:  mem_rd_en = 1'b1;
            ST_CALC:  ;
            ST_WRITE: mem_we = 1'b1;
            ST_RESP: begin
                rsp_valid = 1'b1;
                rsp_data  = old_q;
            end
            ST_FAULT: begin
                fault_valid = 1'b1;
                fault_cause = lat_cause;
            end
            default:  busy = 1'b0;
        endcase
    end

    p_rsp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && !busy));

    p_fault_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |=> (!fault_valid && !busy));

    p_no_dual_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && fault_valid));

    p_write_then_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> rsp_valid);

    p_fault_has_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> (fault_cause != 2'd0));

    p_zero_ext_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !lat_dword) |-> (rsp_data[DATA_W-1:HALF_W] == '0));

    p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rsp_valid && !fault_valid) |=> busy);

    p_idle_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> busy);

endmodule

// File: tb/amo_fetch_unit_tb_top.sv
module amo_fetch_unit_tb_top;

    localparam int DEPTH = 16;
    localparam int AW    = $clog2(DEPTH) + 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid;
    logic [AW-1:0] req_addr;
    logic [4:0]    req_fc;
    logic          req_dword;
    logic [63:0]   req_operand;
    logic          busy;
    logic          rsp_valid;
    logic [63:0]   rsp_data;
    logic          fault_valid;
    logic [1:0]    fault_cause;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [63:0] ref_mem [DEPTH];
    logic [63:0] lfsr = 64'h1234_5678_9abc_def1;

    int          r_kind;
    logic [63:0] r_data;
    logic [1:0]  r_cause;
    int          r_lat;

    always #5 clk = ~clk;

    amo_fetch_unit #(.DEPTH(DEPTH)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .req_fc      (req_fc),
        .req_dword   (req_dword),
        .req_operand (req_operand),
        .busy        (busy),
        .rsp_valid   (rsp_valid),
        .rsp_data    (rsp_data),
        .fault_valid (fault_valid),
        .fault_cause (fault_cause)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bump();
        lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
    endtask

    function automatic logic [63:0] f64(input int fc, input logic [63:0] a, input logic [63:0] b);
        case (fc)
            0:       return a + b;
            1:       return a ^ b;
            2:       return a | b;
            3:       return a & b;
            default: return b;
        endcase
    endfunction

    function automatic logic [31:0] f32(input int fc, input logic [31:0] a, input logic [31:0] b);
        case (fc)
            0:       return a + b;
            1:       return a ^ b;
            2:       return a | b;
            3:       return a & b;
            default: return b;
        endcase
    endfunction

    task automatic issue(input logic [AW-1:0] addr, input int fc, input bit dw, input logic [63:0] opnd);
        @(negedge clk);
        req_addr    = addr;
        req_fc      = fc[4:0];
        req_dword   = dw;
        req_operand = opnd;
        req_valid   = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        r_kind = 0;
        r_lat  = 0;
        for (int i = 1; i <= 20; i++) begin
            if (rsp_valid) begin
                r_kind = 1;
                r_data = rsp_data;
                r_lat  = i;
                break;
            end
            if (fault_valid) begin
                r_kind  = 2;
                r_cause = fault_cause;
                r_lat   = i;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic run(input logic [AW-1:0] addr, input int fc, input bit dw,
                       input logic [63:0] opnd, input string force_tag);
        int          idx;
        bit          hi, mis, impl, resv;
        int          expc;
        logic [63:0] line, old, nl;
        logic [31:0] ow, nw;
        string       tag;
        idx  = int'(addr[AW-1:3]);
        hi   = addr[2];
        mis  = dw ? (addr[2:0] != 3'd0) : (addr[1:0] != 2'd0);
        impl = (fc inside {0, 1, 2, 3, 8});
        resv = (fc inside {4, 5, 6, 7, 16, 24, 25, 28});
        expc = mis ? 1 : (impl ? 0 : (resv ? 2 : 3));
        line = ref_mem[idx];
        if (dw) begin
            old = line;
            nl  = f64(fc, line, opnd);
        end else begin
            ow  = hi ? line[63:32] : line[31:0];
            nw  = f32(fc, ow, opnd[31:0]);
            old = {32'd0, ow};
            nl  = hi ? {nw, line[31:0]} : {line[63:32], nw};
        end
        if (expc == 1)      tag = "R6";
        else if (expc == 2) tag = "R7";
        else if (expc == 3) tag = "R8";
        else if (fc == 0)   tag = "R2";
        else if (fc == 8)   tag = "R4";
        else                tag = "R3";
        if (expc == 0 && !dw) tag = {tag, "/R5"};
        if (force_tag != "") tag = force_tag;

        issue(addr, fc, dw, opnd);
        if (expc != 0) begin
            chk(r_kind == 2, {tag, " fault seen"}, 64'(r_kind), 64'd2);
            chk(r_cause == expc[1:0], {tag, " fault cause"}, 64'(r_cause), 64'(expc));
            chk(r_lat == 1, "R11 fault latency", 64'(r_lat), 64'd1);
        end else begin
            chk(r_kind == 1, {tag, " response seen"}, 64'(r_kind), 64'd1);
            chk(r_data == old, {tag, " old value"}, r_data, old);
            chk(r_lat == 4, "R11 response latency", 64'(r_lat), 64'd4);
            ref_mem[idx] = nl;
        end
        @(negedge clk);
        chk(!rsp_valid && !fault_valid && !busy, (expc != 0) ? "R9 single fault pulse" : "R11 single response pulse",
            64'({rsp_valid, fault_valid, busy}), 64'd0);
    endtask

    task automatic readback_all(input string tag);
        for (int i = 0; i < DEPTH; i++) begin
            run(AW'(i * 8), 2, 1'b1, 64'd0, tag);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R11 watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n       = 1'b0;
        req_valid   = 1'b0;
        req_addr    = '0;
        req_fc      = '0;
        req_dword   = 1'b0;
        req_operand = '0;
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = 64'd0;
        repeat (3) @(negedge clk);
        chk(!busy && !rsp_valid && !fault_valid && fault_cause == 2'd0, "R1 reset outputs",
            64'({busy, rsp_valid, fault_valid, fault_cause}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy, "R1 idle after reset", 64'(busy), 64'd0);

        // R1: memory reads zero after reset
        readback_all("R1");

        // R4: preload every line by doubleword swap
        for (int i = 0; i < DEPTH; i++) begin
            bump();
            run(AW'(i * 8), 8, 1'b1, lfsr, "");
        end

        // R2: wrap cases for both widths
        run(AW'(3 * 8), 8, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, "");
        run(AW'(3 * 8), 0, 1'b1, 64'd1, "R2 doubleword wrap");
        run(AW'(3 * 8), 2, 1'b1, 64'd0, "R2 doubleword wrap result");
        chk(ref_mem[3] == 64'd0, "R2 model wrap", ref_mem[3], 64'd0);
        run(AW'(4 * 8 + 4), 8, 1'b0, 64'h5555_5555_FFFF_FFFF, "");
        run(AW'(4 * 8 + 4), 0, 1'b0, 64'hAAAA_AAAA_0000_0002, "R2 word wrap");
        run(AW'(4 * 8), 2, 1'b1, 64'd0, "R2/R5 word wrap keeps low half");

        // Sweep every code, both sizes, aligned and misaligned offsets
        for (int fc = 0; fc < 32; fc++) begin
            for (int dw = 0; dw < 2; dw++) begin
                for (int k = 0; k < 6; k++) begin
                    int idx;
                    int off;
                    idx = (fc * 3 + k) % DEPTH;
                    if (k < 4)       off = (dw == 1) ? 0 : ((k % 2 == 1) ? 4 : 0);
                    else if (k == 4) off = (dw == 1) ? 4 : 2;
                    else             off = 3;
                    bump();
                    run(AW'(idx * 8 + off), fc, dw[0], lfsr, "");
                end
            end
        end

        // R10: a request held during busy is ignored
        @(negedge clk);
        req_addr    = AW'(5 * 8);
        req_fc      = 5'd8;
        req_dword   = 1'b1;
        req_operand = 64'hC0DE_0000_0000_0005;
        req_valid   = 1'b1;
        @(negedge clk);
        req_addr    = AW'(6 * 8);
        req_operand = 64'hDEAD_BEEF_0000_0006;
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk(rsp_valid && rsp_data == ref_mem[5], "R10 first request answered", rsp_data, ref_mem[5]);
        ref_mem[5] = 64'hC0DE_0000_0000_0005;
        @(negedge clk);
        chk(!busy && !rsp_valid, "R10 no second request", 64'({busy, rsp_valid}), 64'd0);
        run(AW'(6 * 8), 2, 1'b1, 64'd0, "R10 stray target untouched");
        run(AW'(5 * 8), 2, 1'b1, 64'd0, "R10 first target written");

        // R9: memory image after all faulting requests
        readback_all("R9 memory image");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule